// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Unit

This unit keeps watch over the health of a 10 Mb/s twisted-pair port. On the transmit side it produces a one-cycle link pulse strobe at a fixed interval whenever the port is not sending a frame. A frame being received does not stop these pulses. On the receive side it takes two inputs from an upstream receiver: a strobe for each detected link pulse and a flag that is high while frame data is present. From these it decides whether the link is currently valid. It also raises a collision flag when the port transmits and receives at the same time.

Station management sees the link state through a latching-low status bit. Once the bit drops, it stays at zero until it is read, even if the link has recovered in the meantime. The bit can be read at two register addresses. A read at either address returns the latched value and then reloads the latch from the live link state.

All time intervals are given in milliseconds and converted to clock cycles through a ticks-per-millisecond parameter. A test build can therefore shrink them.

Top module: `lnk_integrity`

## Requirements
- R1: With tx_busy low, lp_out pulses high for one cycle every PULSE_MS*TICKS_PER_MS clock cycles, measured rising edge to rising edge.
- R2: While tx_busy is high, lp_out stays low and the pulse timer is held. The first pulse appears PULSE_MS*TICKS_PER_MS cycles after the first cycle with tx_busy low.
- R3: Receive activity (rx_dv high, or rx_lp strobes) does not suppress or shift the outgoing pulses.
- R4: col is high in the cycle after a cycle in which tx_busy and rx_dv are both high, and low otherwise. A received link pulse never raises col.
- R5: From the invalid state, link_up rises in the cycle after the third consecutive rx_lp strobe, provided each strobe followed the previous one by MIN_GAP_MS*TICKS_PER_MS to MAX_GAP_MS*TICKS_PER_MS cycles.
- R6: A strobe that comes sooner than MIN_GAP_MS*TICKS_PER_MS cycles after the previous one restarts the count, and that strobe counts as the first of a new run.
- R7: A cycle with rx_dv high makes link_up high from the next cycle.
- R8: When MAX_GAP_MS*TICKS_PER_MS cycles pass with neither rx_lp nor rx_dv, link_up drops to low.
- R9: The latched status reads 0 if the link was invalid at any point since the last status read or since reset, even if link_up has since returned to 1.
- R10: A status read reloads the latch from link_up. When the link is valid and has not dropped since the previous read, the status reads 1.
- R11: rd_data appears in the cycle after rd_en. The latched bit is at bit 2 for address 1 and at bit 0 for address 17, and all other bits are zero. A read at either address refreshes the single latch both addresses share. Any other address reads as all zeros.
- R12: Reset clears link_up, col, lp_out, rd_data and the latch, and restarts the pulse timer. The first pulse comes PULSE_MS*TICKS_PER_MS cycles after the first cycle out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running clock |
| rst | input | 1 | synchronous active-high reset |
| tx_busy | input | 1 | high while a frame is being transmitted |
| rx_lp | input | 1 | one-cycle strobe per received link pulse |
| rx_dv | input | 1 | high while received frame data is present |
| rd_en | input | 1 | management read strobe |
| rd_addr | input | ADDR_W | management register address |
| lp_out | output | 1 | outgoing link pulse strobe |
| link_up | output | 1 | live link validity |
| col | output | 1 | collision indication |
| rd_data | output | DATA_W | management read data, one cycle after rd_en |

## Verification
The bench builds the unit with TICKS_PER_MS set to 4. This gives a pulse period of 64 cycles, a minimum pulse spacing of 8 cycles and a link-loss timeout of 600 cycles. At these values the bench can time several pulse periods exactly, reach the link-loss timeout, and check both edges of the spacing window in a short run. Directed sequences cover the pulse count with a too-early strobe, a timeout followed by recovery, and the latching-low read order at both addresses. A seeded random phase toggles transmit, receive and strobe inputs to test the collision flag and pulse suppression.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    typedef enum logic {
        LNK_DOWN = 1'b0,
        LNK_UP   = 1'b1
    } lnk_state_e;

    typedef struct packed {
        logic pulse;
        logic data;
    } rx_act_t;

    localparam int unsigned LNK_REG_PRIMARY   = 1;
    localparam int unsigned LNK_BIT_PRIMARY   = 2;
    localparam int unsigned LNK_REG_SECONDARY = 17;
    localparam int unsigned LNK_BIT_SECONDARY = 0;

    function automatic int unsigned ms_to_cyc(input int unsigned ms, input int unsigned tpm);
        return ms * tpm;
    endfunction

    function automatic logic any_activity(input rx_act_t a);
        return a.pulse | a.data;
    endfunction

endpackage

// File: rtl/lnk_pulse_gen.sv
module lnk_pulse_gen #(
    parameter int unsigned PERIOD_CYC = 400000
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_busy,
    output logic lp_out
);
    localparam int unsigned CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CW-1:0] LASTV = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            lp_out <= 1'b0;
        end else if (tx_busy) begin
            cnt    <= '0;
            lp_out <= 1'b0;
        end else if (cnt == LASTV) begin
            cnt    <= '0;
            lp_out <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            lp_out <= 1'b0;
        end
    end

    // R2: a transmitting cycle is never followed by a pulse
    p_tx_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        tx_busy |=> !lp_out);

    // R1: pulses are single-cycle strobes
    p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        lp_out |=> !lp_out);

endmodule

// File: rtl/lnk_monitor.sv
module lnk_monitor
    import lnk_pkg::*;
#(
    parameter int unsigned MIN_CYC = 50000,
    parameter int unsigned MAX_CYC = 3750000,
    parameter int unsigned NEED    = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  rx_act_t act,
    output logic    link_up
);
    localparam int unsigned GW = $clog2(MAX_CYC + 1);
    localparam int unsigned PW = $clog2(NEED + 1);
    localparam logic [GW-1:0] MINV  = GW'(MIN_CYC);
    localparam logic [GW-1:0] MAXV  = GW'(MAX_CYC);
    localparam logic [PW-1:0] LASTP = PW'(NEED - 1);

    lnk_state_e    st;
    logic [GW-1:0] gap;
    logic [PW-1:0] pcnt;
    logic          busy_rx;

    assign busy_rx = any_activity(act);
    assign link_up = (st == LNK_UP);

    // gap = cycles since the most recent activity, saturating at MAXV
    always_ff @(posedge clk) begin
        if (rst)
            gap <= '0;
        else if (busy_rx)
            gap <= GW'(1);
        else if (gap != MAXV)
            gap <= gap + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LNK_DOWN;
            pcnt <= '0;
        end else begin
            case (st)
                LNK_DOWN: begin
                    if (act.data) begin
                        st   <= LNK_UP;
                        pcnt <= '0;
                    end else if (act.pulse) begin
                        if (pcnt == '0) begin
                            pcnt <= PW'(1);
                        end else if (gap >= MINV) begin
                            if (pcnt == LASTP) begin
                                st   <= LNK_UP;
                                pcnt <= '0;
                            end else begin
                                pcnt <= pcnt + 1'b1;
                            end
                        end else begin
                            pcnt <= PW'(1);
                        end
                    end else if (gap == MAXV) begin
                        pcnt <= '0;
                    end
                end
                LNK_UP: begin
                    if (!busy_rx && gap == MAXV) begin
                        st   <= LNK_DOWN;
                        pcnt <= '0;
                    end
                end
                default: begin
                    st   <= LNK_DOWN;
                    pcnt <= '0;
                end
            endcase
        end
    end

    // R7: data activity always leaves the link valid in the next cycle
    p_data_up_r7: assert property (@(posedge clk) disable iff (rst)
        act.data |=> link_up);

    // R8: activity keeps a valid link valid
    p_act_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (link_up && busy_rx) |=> link_up);

    // R5: the pulse count never exceeds what is needed
    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        pcnt <= LASTP);

endmodule

// File: rtl/lnk_status_latch.sv
module lnk_status_latch
    import lnk_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_up,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] ADDR_P = ADDR_W'(LNK_REG_PRIMARY);
    localparam logic [ADDR_W-1:0] ADDR_S = ADDR_W'(LNK_REG_SECONDARY);

    logic              held;
    logic              hit_p;
    logic              hit_s;
    logic              hit;
    logic [DATA_W-1:0] word;

    assign hit_p = rd_en && (rd_addr == ADDR_P);
    assign hit_s = rd_en && (rd_addr == ADDR_S);
    assign hit   = hit_p | hit_s;

    always_comb begin
        word = '0;
        if (hit_p) word[LNK_BIT_PRIMARY]   = held;
        if (hit_s) word[LNK_BIT_SECONDARY] = held;
    end

    always_ff @(posedge clk) begin
        if (rst)
            held <= 1'b0;
        else if (hit)
            held <= link_up;
        else if (!link_up)
            held <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else
            rd_data <= word;
    end

    // R9: with no read, a down link leaves the latch at zero
    p_latch_low_r9: assert property (@(posedge clk) disable iff (rst)
        (!link_up && !hit) |=> !held);

    // R11: addresses outside the two mirrors read as zero
    p_other_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !hit) |=> (rd_data == '0));

    // R11: at most one bit is ever set in the read word
    p_one_bit_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_data));

endmodule

// File: rtl/lnk_integrity.sv
module lnk_integrity
    import lnk_pkg::*;
#(
    parameter int unsigned TICKS_PER_MS  = 25000,
    parameter int unsigned PULSE_MS      = 16,
    parameter int unsigned MIN_GAP_MS    = 2,
    parameter int unsigned MAX_GAP_MS    = 150,
    parameter int unsigned PULSES_NEEDED = 3,
    parameter int unsigned ADDR_W        = 5,
    parameter int unsigned DATA_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_busy,
    input  logic              rx_lp,
    input  logic              rx_dv,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              lp_out,
    output logic              link_up,
    output logic              col,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned PERIOD_CYC = ms_to_cyc(PULSE_MS, TICKS_PER_MS);
    localparam int unsigned MIN_CYC    = ms_to_cyc(MIN_GAP_MS, TICKS_PER_MS);
    localparam int unsigned MAX_CYC    = ms_to_cyc(MAX_GAP_MS, TICKS_PER_MS);

    rx_act_t act;
    assign act.pulse = rx_lp;
    assign act.data  = rx_dv;

    lnk_pulse_gen #(.PERIOD_CYC(PERIOD_CYC)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .tx_busy (tx_busy),
        .lp_out  (lp_out)
    );

    lnk_monitor #(
        .MIN_CYC (MIN_CYC),
        .MAX_CYC (MAX_CYC),
        .NEED    (PULSES_NEEDED)
    ) u_mon (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .link_up (link_up)
    );

    lnk_status_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_stat (
        .clk     (clk),
        .rst     (rst),
        .link_up (link_up),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // collision: transmit and receive data overlap; link pulses are ignored
    always_ff @(posedge clk) begin
        if (rst) col <= 1'b0;
        else     col <= tx_busy && rx_dv;
    end

    // R4: a link pulse without receive data never raises collision
    p_lp_no_col_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_lp && !rx_dv) |=> !col);

    // R4: no collision without transmission
    p_col_needs_tx_r4: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |=> !col);

endmodule

// File: tb/tb_lnk_integrity.sv
module tb_lnk_integrity;

    localparam int unsigned TPM    = 4;
    localparam int unsigned PERIOD = 16 * TPM;
    localparam int unsigned MINC   = 2 * TPM;
    localparam int unsigned MAXC   = 150 * TPM;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_busy = 1'b0;
    logic        rx_lp = 1'b0;
    logic        rx_dv = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic        lp_out;
    logic        link_up;
    logic        col;
    logic [15:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lnk_integrity #(.TICKS_PER_MS(TPM)) dut (
        .clk(clk), .rst(rst), .tx_busy(tx_busy), .rx_lp(rx_lp), .rx_dv(rx_dv),
        .rd_en(rd_en), .rd_addr(rd_addr), .lp_out(lp_out), .link_up(link_up),
        .col(col), .rd_data(rd_data)
    );

    function automatic logic exp_col(input logic tx, input logic dv);
        return tx & dv;
    endfunction

    function automatic logic [15:0] exp_word(input int addr, input logic bitv);
        logic [15:0] w = '0;
        if (addr == 1)  w[2] = bitv;
        if (addr == 17) w[0] = bitv;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_pulse(input int limit, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            tick();
            if (lp_out) begin
                n = i;
                return;
            end
        end
    endtask

    task automatic send_lp();
        rx_lp = 1'b1;
        tick();
        rx_lp = 1'b0;
    endtask

    task automatic do_read(input int addr, output logic [15:0] d);
        rd_en   = 1'b1;
        rd_addr = 5'(addr);
        tick();
        rd_en   = 1'b0;
        d       = rd_data;
    endtask

    initial begin
        logic [15:0] d;
        int n;
        int cnt;
        logic ptx, pdv;

        void'($urandom(32'd1893));
        repeat (3) tick();
        // R12: reset state
        chk(!link_up && !lp_out && !col && rd_data == 0, "R12", {link_up, lp_out, col}, 0);
        rst = 1'b0;
        wait_pulse(PERIOD + 4, n);
        chk(n == PERIOD, "R12 first pulse", n, PERIOD);
        wait_pulse(PERIOD + 4, n);
        chk(n == PERIOD, "R1 interval", n, PERIOD);
        do_read(1, d);
        chk(d == 16'h0, "R9 after reset", d, 0);

        // R6 and R5: too-early strobe restarts the count
        send_lp(); repeat (19) tick();
        send_lp(); repeat (2) tick();
        send_lp(); repeat (19) tick();
        send_lp();
        chk(!link_up, "R6 early strobe restarts", link_up, 0);
        repeat (19) tick();
        send_lp();
        chk(link_up, "R5 third strobe", link_up, 1);

        // R9/R10/R11: latched read order across both addresses
        do_read(17, d);
        chk(d == exp_word(17, 1'b0), "R9 latched low since reset", d, 0);
        do_read(1, d);
        chk(d == exp_word(1, 1'b1), "R10 R11 mirror refreshed", d, 4);
        do_read(17, d);
        chk(d == exp_word(17, 1'b1), "R10 stays valid", d, 1);
        do_read(5, d);
        chk(d == 16'h0, "R11 other address", d, 0);

        // R8: timeout
        rx_dv = 1'b1; tick(); rx_dv = 1'b0;
        repeat (MAXC - 5) tick();
        chk(link_up, "R8 before timeout", link_up, 1);
        repeat (10) tick();
        chk(!link_up, "R8 after timeout", link_up, 0);

        // R7: data recovers at once, latch still shows the drop
        rx_dv = 1'b1; tick(); rx_dv = 1'b0;
        chk(link_up, "R7 data activity", link_up, 1);
        do_read(1, d);
        chk(d == exp_word(1, 1'b0), "R9 drop remembered", d, 0);
        do_read(17, d);
        chk(d == exp_word(17, 1'b1), "R10 reload after read", d, 1);

        // R3: pulses keep going during reception; R4 strobes give no col
        rx_dv = 1'b1;
        wait_pulse(PERIOD + 4, n);
        chk(n > 0, "R3 pulse during rx", n, 1);
        wait_pulse(PERIOD + 4, n);
        chk(n == PERIOD, "R3 interval during rx", n, PERIOD);
        rx_dv = 1'b0;
        send_lp();
        chk(!col, "R4 strobe no col", col, 0);

        // R2: transmission suppresses
        tx_busy = 1'b1;
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            tick();
            if (lp_out) cnt++;
        end
        chk(cnt == 0, "R2 no pulse while tx", cnt, 0);
        rx_dv = 1'b1; tick();
        chk(col, "R4 tx and rx overlap", col, 1);
        rx_dv = 1'b0;
        tx_busy = 1'b0;
        wait_pulse(PERIOD + 4, n);
        chk(n == PERIOD, "R2 first pulse after tx", n, PERIOD);

        // random phase
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(15) == 0) tx_busy = ~tx_busy;
            if ($urandom_range(7) == 0)  rx_dv = ~rx_dv;
            rx_lp = ($urandom_range(19) == 0);
            ptx = tx_busy;
            pdv = rx_dv;
            tick();
            chk(col == exp_col(ptx, pdv), "R4 random col", col, exp_col(ptx, pdv));
            if (ptx) chk(!lp_out, "R2 random quiet", lp_out, 0);
            if (pdv) chk(link_up, "R7 random data", link_up, 1);
        end
        rx_lp = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule